// File: doc/BRIEF.md
# Slave-Select Line Controller

This block drives the chip-select lines that a serial master port uses to address its slaves. A 32-bit control word holds three fields. The first turns on automatic mode. The second sets whether a selected line is driven high or low. The third is a small field with one bit per select line. Software writes the word through a single-register write port and can read it back at any time through a read port.

In manual mode, software owns the lines: each select bit directly marks its line active or inactive. In automatic mode, the select bits only name the target slave. The named line goes active when the shift engine reports a transfer start, and it falls back to inactive when the engine reports the transfer is done. The block also keeps a busy flag for that window.

Only one slave may be addressed at a time. If several select bits are set, the lowest-numbered one wins. The target should be configured before a transfer is started. All select outputs are registered.

Top module: `ssel_ctrl`

## Requirements
- R1: After reset the control word reads 0, `xfer_busy` is 0 and every select line is high, which is inactive for the default active-low polarity.
- R2: Field layout of the control word: bit 3 enables automatic mode, bit 2 selects active-high polarity, and bits 1:0 pick the lines (bit i is line i). Bits 31:4 always read 0, whatever value was written.
- R3: In manual mode (bit 3 = 0), a line whose select bit is 1 is driven active and a line whose bit is 0 is driven inactive.
- R4: With bit 2 = 0 an active line is driven 0; with bit 2 = 1 an active line is driven 1. Inactive lines are driven to the opposite level.
- R5: When more than one select bit is set, only the lowest-numbered set line is driven active, so at most one line is ever active.
- R6: In automatic mode the chosen line is inactive while no transfer runs. It is active from the clock edge that samples `xfer_start` up to the edge that samples `xfer_done`, and it is inactive again from that edge on.
- R7: `xfer_busy` rises on the edge that samples `xfer_start` while idle, and falls on the edge that samples `xfer_done` while busy.
- R8: A `xfer_start` that arrives while busy has no effect on `xfer_busy` or the lines. A `xfer_done` that arrives while idle has no effect.
- R9: A register write changes the read-back value and the select lines on the same clock edge that samples the write, so both are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Current control word, reserved bits zero |
| xfer_start | input | 1 | One-cycle pulse from the shift engine: transfer begins |
| xfer_done | input | 1 | One-cycle pulse from the shift engine: transfer finished |
| xfer_busy | output | 1 | High while a transfer is in progress |
| sel_o | output | 2 | Registered select lines, one per slave |

## Verification
The assertions assume that `xfer_start` and `xfer_done` are single-cycle pulses from one shift engine. They also assume that the select field is set up before a transfer begins, so the chosen slave does not change in the middle of an automatic transfer. The random part of the bench writes the control word only while the block is idle, and it also issues stray pulses: starts while busy, and dones while idle. The directed part covers overlapping select bits, both polarities, and back-to-back transfers.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_SEL = 2;
    localparam int CFG_W   = NUM_SEL + 2;

    typedef logic [NUM_SEL-1:0] sel_vec_t;

    typedef struct packed {
        logic     auto_en;
        logic     act_high;
        sel_vec_t pick;
    } ssel_cfg_t;

    function automatic sel_vec_t lowest_set(input sel_vec_t v);
        sel_vec_t r;
        logic     seen;
        r    = '0;
        seen = 1'b0;
        for (int i = 0; i < NUM_SEL; i++) begin
            if (v[i] && !seen) begin
                r[i] = 1'b1;
                seen = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic sel_vec_t to_level(input sel_vec_t act, input logic act_high);
        return act_high ? act : ~act;
    endfunction

endpackage

// File: rtl/ssel_cfg_reg.sv
module ssel_cfg_reg
    import ssel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output ssel_cfg_t        cfg_q,
    output ssel_cfg_t        cfg_d,
    output logic [REG_W-1:0] rdata
);
    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:CFG_W];

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = ssel_cfg_t'(wdata[CFG_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign rdata = {{(REG_W-CFG_W){1'b0}}, cfg_q};

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rdata[REG_W-1:CFG_W] == '0);

    p_write_visible_r9: assert property (@(posedge clk) disable iff (rst)
        we |=> (rdata[CFG_W-1:0] == $past(wdata[CFG_W-1:0])));

endmodule

// File: rtl/ssel_xfer_track.sv
module ssel_xfer_track (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic done,
    output logic busy_q,
    output logic busy_d
);
    always_comb begin
        if (busy_q) busy_d = !done;
        else        busy_d = start;
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy_d;
    end

    p_start_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && start) |=> busy_q);

    p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && done) |=> !busy_q);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start && !done) |=> busy_q);

    p_done_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && done && !start) |=> !busy_q);

endmodule

// File: rtl/ssel_line_drive.sv
module ssel_line_drive
    import ssel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ssel_cfg_t cfg_d,
    input  logic      busy_d,
    input  ssel_cfg_t cfg_q,
    input  logic      busy_q,
    output sel_vec_t  sel_o
);
    sel_vec_t want;
    sel_vec_t lvl_d;
    sel_vec_t act_now;

    always_comb begin
        want = lowest_set(cfg_d.pick);
        if (cfg_d.auto_en && !busy_d) want = '0;
        lvl_d = to_level(want, cfg_d.act_high);
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) sel_o[g] <= 1'b1;
            else     sel_o[g] <= lvl_d[g];
        end
    end

    assign act_now = cfg_q.act_high ? sel_o : ~sel_o;

    p_one_active_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_now));

    p_manual_follow_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.auto_en |-> (act_now == lowest_set(cfg_q.pick)));

    p_auto_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.auto_en && !busy_q) |-> (act_now == '0));

    p_auto_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.auto_en && busy_q) |-> (act_now == lowest_set(cfg_q.pick)));

endmodule

// File: rtl/ssel_ctrl.sv
module ssel_ctrl
    import ssel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             xfer_start,
    input  logic             xfer_done,
    output logic             xfer_busy,
    output logic [NUM_SEL-1:0] sel_o
);
    ssel_cfg_t cfg_q;
    ssel_cfg_t cfg_d;
    logic      busy_d;

    ssel_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg_q (cfg_q),
        .cfg_d (cfg_d),
        .rdata (reg_rdata)
    );

    ssel_xfer_track u_xfer (
        .clk    (clk),
        .rst    (rst),
        .start  (xfer_start),
        .done   (xfer_done),
        .busy_q (xfer_busy),
        .busy_d (busy_d)
    );

    ssel_line_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .cfg_d  (cfg_d),
        .busy_d (busy_d),
        .cfg_q  (cfg_q),
        .busy_q (xfer_busy),
        .sel_o  (sel_o)
    );

endmodule

// File: tb/test_ssel_ctrl.sv
`timescale 1ns/1ps
module test_ssel_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        xfer_start;
    logic        xfer_done;
    logic        xfer_busy;
    logic [1:0]  sel_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [3:0] m_cfg;
    logic       m_busy;

    always #2.5 clk = ~clk;

    ssel_ctrl i_ssel_ctrl (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xfer_start (xfer_start),
        .xfer_done  (xfer_done),
        .xfer_busy  (xfer_busy),
        .sel_o      (sel_o)
    );

    // expected line levels from the requirements: R3/R4/R5/R6
    function automatic logic [1:0] exp_sel(input logic [3:0] c, input logic b);
        logic [1:0] act;
        if (c[0])      act = 2'b01;
        else if (c[1]) act = 2'b10;
        else           act = 2'b00;
        if (c[3] && !b) act = 2'b00;
        return c[2] ? act : ~act;
    endfunction

    task automatic chk(input string tag);
        logic [1:0] es;
        es = exp_sel(m_cfg, m_busy);
        checks++;
        if (sel_o !== es) begin
            fails++;
            $display("FAIL %s sel_o actual=%b expected=%b", tag, sel_o, es);
        end
        checks++;
        if (xfer_busy !== m_busy) begin
            fails++;
            $display("FAIL %s busy actual=%b expected=%b", tag, xfer_busy, m_busy);
        end
        checks++;
        if (reg_rdata !== {28'd0, m_cfg}) begin
            fails++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, reg_rdata, {28'd0, m_cfg});
        end
    endtask

    // one clock with the given inputs; model updated per R2/R7/R8/R9
    task automatic cyc(input logic we, input logic [31:0] wd,
                       input logic st, input logic dn, input string tag);
        reg_we = we; reg_wdata = wd; xfer_start = st; xfer_done = dn;
        @(posedge clk); #1;
        if (m_busy) m_busy = !dn;
        else        m_busy = st;
        if (we) m_cfg = wd[3:0];
        reg_we = 1'b0; xfer_start = 1'b0; xfer_done = 1'b0;
        chk(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; reg_we = 1'b0; reg_wdata = '0; xfer_start = 1'b0; xfer_done = 1'b0;
        m_cfg = '0; m_busy = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1 reset");

        // R2: reserved bits dropped; manual, active high, line0
        cyc(1, 32'hFFFF_FFF5, 0, 0, "R2 reserved/R4 high");
        // R3 manual active low
        cyc(1, 32'h1, 0, 0, "R3 line0 on R9");
        cyc(1, 32'h0, 0, 0, "R3 all off");
        cyc(1, 32'h2, 0, 0, "R3 line1 on");
        // R5 priority, both polarities
        cyc(1, 32'h3, 0, 0, "R5 low pol");
        cyc(1, 32'h7, 0, 0, "R5 high pol R4");
        // R6 auto, low polarity, line1
        cyc(1, 32'hA, 0, 0, "R6 idle");
        cyc(0, 0, 0, 1, "R8 done idle");
        cyc(0, 0, 1, 0, "R6 start R7");
        cyc(0, 0, 0, 0, "R6 hold");
        cyc(0, 0, 1, 0, "R8 start busy");
        cyc(0, 0, 0, 1, "R6 done R7");
        cyc(0, 0, 0, 0, "R6 after");
        // back to back, start+done while idle -> starts
        cyc(0, 0, 1, 1, "R8 start+done idle");
        cyc(0, 0, 1, 1, "R7 done wins busy");
        // auto, high polarity, both bits set
        cyc(1, 32'hF, 0, 0, "R6 high idle");
        cyc(0, 0, 1, 0, "R5 auto start");
        cyc(0, 0, 0, 1, "R6 high done");

        for (int i = 0; i < 400; i++) begin
            logic we, st, dn;
            logic [31:0] wd;
            we = (!m_busy) && ($urandom % 6 == 0);
            wd = $urandom;
            st = ($urandom % 4 == 0);
            dn = ($urandom % 5 == 0);
            cyc(we, wd, st, dn, "R6/R7 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule